// File: doc/BRIEF.md
# Audio Master-Mode Frame and Bit Clock Divider

This block produces the frame clock and the bit clock of a serial audio port when the port is the clock master. Both clocks come from one master clock, `mclk`. A 3-bit ratio code sets how many master-clock cycles make one frame. A 2-bit bit-clock code sets how many bit-clock periods occur in each frame. When the master-enable input is low, the block is a slave: both outputs stay low and the divider counters are held at zero.

The ratio can be one of 128, 192, 256, 384, 512, 768 or 1152 master clocks per frame. Some of these ratios, combined with the bit-clock count, give a whole-number divisor. Others give a divisor that ends in one half. For a half divisor the block alternates a longer and a shorter bit period, so that every frame still holds exactly the requested number of bit clocks. A divisor of one is produced by passing through the inverted master clock.

The ratio code and the bit-clock code are sampled only at frame boundaries. A change made in the middle of a frame therefore never produces a truncated frame.

Top module: `audio_mclk_divider`

## Requirements
- R1: Ratio code `rate` gives the frame length in `mclk` cycles: 0→128, 1→192, 2→256, 3→384, 4→512, 5→768, 6→1152.
- R2: Ratio code 7 is reserved and behaves exactly like code 2 (256 cycles per frame).
- R3: Bit-clock code `bsel` gives the number of `bclk` falling edges per frame: 0→64, 1→128, 2→256, 3→64.
- R4: When the ratio is 128 or 192 and `bsel` is 2, the frame holds 128 bit clocks.
- R5: `lrclk` is high for the first half of each frame and low for the second half. Each `lrclk` edge coincides with a `bclk` falling edge.
- R6: Each bit period starts low. For a period of L ≥ 2 `mclk` cycles, `bclk` is high for the last floor(L/2) cycles. For a period of 1 cycle, `bclk` equals inverted `mclk`, so it is high only in the second half of the cycle.
- R7: With `bsel` 0 and a ratio of 192 or 1152, `bclk` is high for one third of each period and low for two thirds.
- R8: A new `rate` or `bsel` value takes effect only at the next frame start. The frame in progress keeps its length and its bit-clock count.
- R9: While `master` is 0 (and during reset), `lrclk` and `bclk` are 0 and the counters are held at zero. The first cycle after `master` rises begins a frame with `lrclk` high.
- R10: When frame length divided by bit count is a half number, bit periods alternate between the rounded-up and the rounded-down length, starting with the longer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every counter runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = master mode (outputs run), 0 = slave mode (outputs low) |
| rate | input | 3 | Master clocks per frame code |
| bsel | input | 2 | Bit clocks per frame code |
| lrclk | output | 1 | Frame clock |
| bclk | output | 1 | Bit clock |

## Verification
On every cycle, the assertions check the following. In slave mode the frame clock stays low and the counters are zero. The frame and bit counters stay inside the current frame and period. The latched configuration changes only at a frame start. The frame clock toggles only at the start of an even bit period. The bench's scenarios cover the rest, by counting over whole frames. They measure frame length, bit-clock falling edges and high time for every ratio and bit-clock code, including the override, the one-third duty, half divisors and the reserved code. They also show that a change in mid-frame leaves that frame intact, and that a frame restarts cleanly when master mode is entered.

// File: rtl/audio_mclk_divider.sv
module audio_mclk_divider (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       master,
  input  logic [2:0] rate,
  input  logic [1:0] bsel,
  output logic       lrclk,
  output logic       bclk
);

  logic [2:0]  cur_rate;
  logic [1:0]  cur_bsel;
  logic [10:0] fcnt;
  logic [4:0]  cnt;
  logic        par;

  logic [10:0] ratio;
  logic [3:0]  lg_bits;
  logic [11:0] pair_w;
  logic [5:0]  len, hi;
  logic        third, last_bit, last_frame;

  always_comb begin
    case (cur_rate)
      3'd0:    ratio = 11'd128;
      3'd1:    ratio = 11'd192;
      3'd3:    ratio = 11'd384;
      3'd4:    ratio = 11'd512;
      3'd5:    ratio = 11'd768;
      3'd6:    ratio = 11'd1152;
      default: ratio = 11'd256;
    endcase
    case (cur_bsel)
      2'd1:    lg_bits = 4'd7;
      2'd2:    lg_bits = (ratio <= 11'd192) ? 4'd7 : 4'd8;
      default: lg_bits = 4'd6;
    endcase
  end

  assign pair_w = {ratio, 1'b0} >> lg_bits;
  assign len    = par ? 6'(pair_w >> 1) : 6'((pair_w + 12'd1) >> 1);
  assign third  = (cur_bsel == 2'd0) && (cur_rate == 3'd1 || cur_rate == 3'd6);
  assign hi     = third ? len / 6'd3 : len >> 1;

  assign last_bit   = ({1'b0, cnt} == len - 6'd1);
  assign last_frame = (fcnt == ratio - 11'd1);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rate <= 3'b010;
      cur_bsel <= 2'b00;
      fcnt     <= '0;
      cnt      <= '0;
      par      <= 1'b0;
    end else if (!master || last_frame) begin
      cur_rate <= rate;
      cur_bsel <= bsel;
      fcnt     <= '0;
      cnt      <= '0;
      par      <= 1'b0;
    end else begin
      fcnt <= fcnt + 11'd1;
      if (last_bit) begin
        cnt <= '0;
        par <= ~par;
      end else begin
        cnt <= cnt + 5'd1;
      end
    end
  end

  assign lrclk = master & (fcnt < (ratio >> 1));
  assign bclk  = master & ((len == 6'd1) ? ~mclk : ({1'b0, cnt} >= len - hi));

endmodule

module audio_mclk_divider_chk (
  input logic        mclk,
  input logic        rst_n,
  input logic        master,
  input logic        lrclk,
  input logic [2:0]  cur_rate,
  input logic [1:0]  cur_bsel,
  input logic [10:0] fcnt,
  input logic [4:0]  cnt,
  input logic        par,
  input logic [10:0] ratio,
  input logic [5:0]  len
);

  assert_slave_quiet_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    !master |-> !lrclk);

  assert_hold_counters_R9: assert property (@(posedge mclk) disable iff (!rst_n)
    !master |=> (fcnt == 11'd0 && cnt == 5'd0 && !par));

  assert_cfg_stable_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    (master && fcnt != 11'd0) |-> ($stable(cur_rate) && $stable(cur_bsel)));

  assert_lr_on_bit_edge_R5: assert property (@(posedge mclk) disable iff (!rst_n)
    (master && $past(master) && lrclk != $past(lrclk)) |-> (cnt == 5'd0 && !par));

  assert_frame_range_R1: assert property (@(posedge mclk) disable iff (!rst_n)
    fcnt < ratio);

  assert_bit_range_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    {1'b0, cnt} < len);

endmodule

bind audio_mclk_divider audio_mclk_divider_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .master(master), .lrclk(lrclk),
  .cur_rate(cur_rate), .cur_bsel(cur_bsel), .fcnt(fcnt), .cnt(cnt),
  .par(par), .ratio(ratio), .len(len)
);

// File: tb/tb_audio_mclk_divider.sv
`timescale 1ns/1ps
module tb_audio_mclk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master = 1'b0;
  logic [2:0] rate = 3'd2;
  logic [1:0] bsel = 2'd0;
  logic       lrclk, bclk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  audio_mclk_divider dut (
    .mclk(clk), .rst_n(rst_n), .master(master), .rate(rate), .bsel(bsel),
    .lrclk(lrclk), .bclk(bclk)
  );

  // {rate, bsel, frame cycles, bclk falls, bclk high half-samples}
  localparam int NV = 15;
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 2'd0, 11'd128,  9'd64,  12'd128},
    {3'd0, 2'd2, 11'd128,  9'd128, 12'd128},   // override
    {3'd1, 2'd0, 11'd192,  9'd64,  12'd128},   // one-third duty
    {3'd1, 2'd2, 11'd192,  9'd128, 12'd192},   // override, half divisor
    {3'd1, 2'd1, 11'd192,  9'd128, 12'd192},
    {3'd2, 2'd0, 11'd256,  9'd64,  12'd256},
    {3'd2, 2'd2, 11'd256,  9'd256, 12'd256},
    {3'd3, 2'd0, 11'd384,  9'd64,  12'd384},
    {3'd3, 2'd2, 11'd384,  9'd256, 12'd384},
    {3'd4, 2'd1, 11'd512,  9'd128, 12'd512},
    {3'd5, 2'd3, 11'd768,  9'd64,  12'd768},
    {3'd6, 2'd0, 11'd1152, 9'd64,  12'd768},
    {3'd6, 2'd2, 11'd1152, 9'd256, 12'd1024},
    {3'd6, 2'd1, 11'd1152, 9'd128, 12'd1024},
    {3'd7, 2'd1, 11'd256,  9'd128, 12'd256}    // reserved code
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic half();
    @(posedge clk or negedge clk);
    #1;
  endtask

  task automatic measure(input int chg_at, input logic [2:0] nr, input logic [1:0] nb,
                         output int n, output int falls, output int lrh, output int bh);
    int guard;
    int n2;
    logic pl, pb;
    guard = 0;
    pl = lrclk;
    half();
    while (!(!pl && lrclk) && guard < 6000) begin
      pl = lrclk;
      half();
      guard++;
    end
    n2 = 0; falls = 0; lrh = 0; bh = 0;
    do begin
      lrh += int'(lrclk);
      bh  += int'(bclk);
      n2++;
      if (n2 == chg_at) begin
        rate = nr;
        bsel = nb;
      end
      pl = lrclk;
      pb = bclk;
      half();
      if (pb && !bclk) falls++;
    end while (!(!pl && lrclk) && n2 < 6000);
    n = n2 / 2;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, falls, lrh, bh, bad;
    repeat (3) half();
    chk("R9 reset lrclk", int'(lrclk), 0);
    chk("R9 reset bclk", int'(bclk), 0);
    rst_n = 1'b1;
    repeat (4) half();
    master = 1'b1;
    half();
    chk("R9 frame starts high", int'(lrclk), 1);

    for (int i = 0; i < NV; i++) begin
      rate = VEC[i][36:34];
      bsel = VEC[i][33:32];
      measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
      chk("R1 frame length", n, int'(VEC[i][31:21]));
      chk("R3 bclk per frame", falls, int'(VEC[i][20:12]));
      chk("R5 lrclk high half", lrh, int'(VEC[i][31:21]));
      chk("R6 bclk high time", bh, int'(VEC[i][11:0]));
    end

    rate = 3'd7; bsel = 2'd0;
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R2 reserved ratio", n, 256);

    rate = 3'd0; bsel = 2'd2;
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R4 override at 128", falls, 128);

    rate = 3'd6; bsel = 2'd0;
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R7 one-third high", bh * 3, n * 2);

    rate = 3'd3; bsel = 2'd2;
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R10 half divisor count", falls, 256);
    chk("R10 half divisor length", n, 384);

    rate = 3'd2; bsel = 2'd0;
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    measure(100, 3'd0, 2'd1, n, falls, lrh, bh);
    chk("R8 frame kept length", n, 256);
    chk("R8 frame kept bclk", falls, 64);
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R8 new length applied", n, 128);
    chk("R8 new bclk applied", falls, 128);

    master = 1'b0;
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      half();
      if (lrclk || bclk) bad++;
    end
    chk("R9 slave outputs low", bad, 0);
    rate = 3'd4; bsel = 2'd1;
    half();
    master = 1'b1;
    half();
    chk("R9 restart lrclk high", int'(lrclk), 1);
    measure(-1, 3'd0, 2'd0, n, falls, lrh, bh);
    chk("R9 restart frame", n, 512);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule